// File: doc/BRIEF.md
# Switching Amplifier Mode and Protection Controller

This block is the control state machine of a two-channel switching power amplifier. It takes an active-low control reset and an active-low mute from the system. It also takes three already-synchronized die-temperature comparator bits and one overcurrent flag per output transistor. From these it decides whether the modulator runs and whether the output stage switches or sits in tri-state.

After the control reset is released, the block runs a fixed initialization phase. It then waits muted, with the modulator running and the stage undriven. Releasing mute starts a timed soft start before switching begins. Asserting mute lets switching continue for a timed interval and then stops it.

Two thermal limits act with hysteresis against a lower restore limit. The upper limit forces the stage off until the die has cooled, and the block then restarts through soft start. An overcurrent in any transistor forces the muted state and stays latched until mute or the control reset is released again. Three active-low error outputs report warning, shutdown and overcurrent.

Top module: `amp_mode_ctrl`

## Requirements
- R1: While the synchronized control reset is low the modulator enable and stage enable are 0. After system reset every error output is 1.
- R2: Three clock edges after amp_reset_ni rises, the block spends INIT_CYCLES cycles initializing. It then enters the muted idle state: mod_en_o=1, stage_en_o=0.
- R3: From muted idle, stage_en_o rises exactly UNMUTE_CYCLES+3 clock edges after mute_ni goes high (two synchronizer stages, one decision edge, then the soft-start count).
- R4: From run, stage_en_o falls exactly MUTE_CYCLES+3 clock edges after mute_ni goes low.
- R5: err_warn_no goes low one edge after temp_hot_i or temp_crit_i is seen high. It returns high only on an edge where temp_cool_i is high and neither of the other two is high.
- R6: err_shut_no goes low one edge after temp_crit_i is seen high, and stage_en_o is 0 from the second edge on.
- R7: The shutdown holds until temp_cool_i is seen high. The block then re-enters soft start, so stage_en_o rises UNMUTE_CYCLES+2 edges after temp_cool_i rises (mute released).
- R8: Any one bit of oc_i high drives err_oc_no low on the next edge and stage_en_o low on the edge after. The fault stays latched after oc_i returns to 0.
- R9: The latched overcurrent clears on the third edge after mute_ni or amp_reset_ni goes from low to high. Nothing else clears it.
- R10: If an overcurrent flag is high on the same edge as a clearing release, the fault stays set.
- R11: If mute_ni returns high while switching is still winding down after a mute, the block goes straight back to run, and stage_en_o never drops.
- R12: If mute_ni goes low again during soft start, the block returns to muted idle and stage_en_o never rises.
- R13: amp_reset_ni low forces the stopped state from any state. mod_en_o falls three edges after amp_reset_ni falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| amp_reset_ni | input | 1 | Control reset from the host, active low, asynchronous |
| mute_ni | input | 1 | Mute request, active low, asynchronous |
| temp_hot_i | input | 1 | Die above warning limit (synchronized) |
| temp_crit_i | input | 1 | Die above shutdown limit (synchronized) |
| temp_cool_i | input | 1 | Die below restore limit (synchronized) |
| oc_i | input | NUM_SW | Per-transistor overcurrent flags |
| mod_en_o | output | 1 | Modulator run enable |
| stage_en_o | output | 1 | 1 = output stage switching, 0 = tri-state |
| err_warn_no | output | 1 | Thermal warning, active low |
| err_shut_no | output | 1 | Thermal shutdown, active low |
| err_oc_no | output | 1 | Latched overcurrent, active low, |

## Verification
The overcurrent latch can be set by a transistor flag and cleared by a mute or reset release on the same edge. The bench provokes this by holding one oc_i bit high across a full mute pulse, so the detected rising edge of the synchronized mute lands while the flag is still high. It then checks that err_oc_no stays low and the stage stays off (set wins). A thermal shutdown that arrives while a mute is winding down is also provoked. In that case the drop must come from the fault, at once, and not from the mute counter. A behavioural model in the bench follows both cases edge by edge.

// File: rtl/amp_ctrl_pkg.sv
package amp_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_INIT = 3'd1,
    ST_IDLE = 3'd2,
    ST_SOFT = 3'd3,
    ST_RUN  = 3'd4,
    ST_STOP = 3'd5
  } amp_state_e;
endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/amp_thermal_mon.sv
module amp_thermal_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic temp_hot_i,
  input  logic temp_crit_i,
  input  logic temp_cool_i,
  output logic warn_o,
  output logic shut_o
);
  logic warn_q, shut_q;

  // set beats restore when comparators disagree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      if (temp_hot_i || temp_crit_i) warn_q <= 1'b1;
      else if (temp_cool_i)          warn_q <= 1'b0;
      if (temp_crit_i)               shut_q <= 1'b1;
      else if (temp_cool_i)          shut_q <= 1'b0;
    end
  end

  assign warn_o = warn_q;
  assign shut_o = shut_q;

  assert_warn_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_q && !temp_cool_i) |=> warn_q);
  assert_shut_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_crit_i |=> shut_q);
  assert_shut_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut_q && !temp_cool_i) |=> shut_q);
endmodule

// File: rtl/amp_oc_latch.sv
module amp_oc_latch #(
  parameter int NUM_SW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SW-1:0] oc_i,
  input  logic              amp_rst_s_i,
  input  logic              mute_s_i,
  output logic              oc_o
);
  logic rst_d_q, mute_d_q, oc_q;
  logic release_ev, any_oc;

  assign any_oc     = |oc_i;
  assign release_ev = (amp_rst_s_i && !rst_d_q) || (mute_s_i && !mute_d_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_d_q  <= 1'b0;
      mute_d_q <= 1'b0;
      oc_q     <= 1'b0;
    end else begin
      rst_d_q  <= amp_rst_s_i;
      mute_d_q <= mute_s_i;
      if (any_oc)          oc_q <= 1'b1;
      else if (release_ev) oc_q <= 1'b0;
    end
  end

  assign oc_o = oc_q;

  assert_oc_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_oc |=> oc_q);
  assert_oc_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_q && $stable(mute_s_i) && $stable(amp_rst_s_i)) |=> oc_q);
endmodule

// File: rtl/amp_mode_fsm.sv
module amp_mode_fsm
  import amp_ctrl_pkg::*;
#(
  parameter int INIT_CYCLES   = 256,
  parameter int UNMUTE_CYCLES = 4250,
  parameter int MUTE_CYCLES   = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic amp_rst_s_i,
  input  logic mute_s_i,
  input  logic shut_i,
  input  logic oc_i,
  output logic mod_en_o,
  output logic stage_en_o
);
  localparam int MAX_A   = (INIT_CYCLES > UNMUTE_CYCLES) ? INIT_CYCLES : UNMUTE_CYCLES;
  localparam int MAX_LEN = (MAX_A > MUTE_CYCLES) ? MAX_A : MUTE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] UNM_LAST  = CNT_W'(UNMUTE_CYCLES - 1);
  localparam logic [CNT_W-1:0] MUTE_LAST = CNT_W'(MUTE_CYCLES - 1);
  localparam logic [CNT_W-1:0] MAX_LAST  = CNT_W'(MAX_LEN - 1);

  amp_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic fault;

  assign fault = shut_i || oc_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    if (!amp_rst_s_i) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_INIT;
          cnt_d   = '0;
        end
        ST_INIT: begin
          if (cnt_q == INIT_LAST) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end
        end
        ST_IDLE: begin
          cnt_d = '0;
          if (mute_s_i && !fault) state_d = ST_SOFT;
        end
        ST_SOFT: begin
          if (!mute_s_i || fault) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else if (cnt_q == UNM_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end
        end
        ST_RUN: begin
          cnt_d = '0;
          if (fault)          state_d = ST_IDLE;
          else if (!mute_s_i) state_d = ST_STOP;
        end
        ST_STOP: begin
          if (fault) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else if (mute_s_i) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else if (cnt_q == MUTE_LAST) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end
        end
        default: begin
          state_d = ST_OFF;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mod_en_o   = (state_q != ST_OFF);
  assign stage_en_o = (state_q == ST_RUN) || (state_q == ST_STOP);

  assert_off_on_reset_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_rst_s_i |=> (state_q == ST_OFF));
  assert_fault_drops_stage_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> !stage_en_o);
  assert_switch_via_soft_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_en_o) |-> ($past(state_q) == ST_SOFT));
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_LAST);
endmodule

// File: rtl/amp_mode_ctrl.sv
module amp_mode_ctrl #(
  parameter int NUM_SW        = 8,
  parameter int INIT_CYCLES   = 256,
  parameter int UNMUTE_CYCLES = 4250,
  parameter int MUTE_CYCLES   = 1250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              amp_reset_ni,
  input  logic              mute_ni,
  input  logic              temp_hot_i,
  input  logic              temp_crit_i,
  input  logic              temp_cool_i,
  input  logic [NUM_SW-1:0] oc_i,
  output logic              mod_en_o,
  output logic              stage_en_o,
  output logic              err_warn_no,
  output logic              err_shut_no,
  output logic              err_oc_no
);
  logic [1:0] ctl_s;
  logic amp_rst_s, mute_s, warn, shut, oc_lat;

  amp_sync #(.W(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({mute_ni, amp_reset_ni}),
    .sync_o  (ctl_s)
  );
  assign amp_rst_s = ctl_s[0];
  assign mute_s    = ctl_s[1];

  amp_thermal_mon u_therm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .temp_hot_i  (temp_hot_i),
    .temp_crit_i (temp_crit_i),
    .temp_cool_i (temp_cool_i),
    .warn_o      (warn),
    .shut_o      (shut)
  );

  amp_oc_latch #(.NUM_SW(NUM_SW)) u_oc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .oc_i        (oc_i),
    .amp_rst_s_i (amp_rst_s),
    .mute_s_i    (mute_s),
    .oc_o        (oc_lat)
  );

  amp_mode_fsm #(
    .INIT_CYCLES   (INIT_CYCLES),
    .UNMUTE_CYCLES (UNMUTE_CYCLES),
    .MUTE_CYCLES   (MUTE_CYCLES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .amp_rst_s_i (amp_rst_s),
    .mute_s_i    (mute_s),
    .shut_i      (shut),
    .oc_i        (oc_lat),
    .mod_en_o    (mod_en_o),
    .stage_en_o  (stage_en_o)
  );

  assign err_warn_no = ~warn;
  assign err_shut_no = ~shut;
  assign err_oc_no   = ~oc_lat;

  assert_stage_needs_mod_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_en_o |-> mod_en_o);
endmodule

// File: tb/amp_mode_ctrl_tb.sv
module amp_mode_ctrl_tb;
  localparam int NSW = 8;
  localparam int INI = 16;
  localparam int UNM = 27;
  localparam int MUT = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic amp_reset_ni = 1'b0, mute_ni = 1'b0;
  logic temp_hot_i = 1'b0, temp_crit_i = 1'b0, temp_cool_i = 1'b1;
  logic [NSW-1:0] oc_i = '0;
  logic mod_en_o, stage_en_o, err_warn_no, err_shut_no, err_oc_no;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  amp_mode_ctrl #(.NUM_SW(NSW), .INIT_CYCLES(INI), .UNMUTE_CYCLES(UNM),
                  .MUTE_CYCLES(MUT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .amp_reset_ni(amp_reset_ni), .mute_ni(mute_ni),
    .temp_hot_i(temp_hot_i), .temp_crit_i(temp_crit_i), .temp_cool_i(temp_cool_i),
    .oc_i(oc_i), .mod_en_o(mod_en_o), .stage_en_o(stage_en_o),
    .err_warn_no(err_warn_no), .err_shut_no(err_shut_no), .err_oc_no(err_oc_no));

  // behavioural reference: 0 off,1 init,2 idle,3 soft,4 run,5 stop
  int m_mode, m_cnt;
  bit r_a, r_b, r_c, u_a, u_b, u_c, m_warn, m_shut, m_oc;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_cnt = 0;
      {r_a, r_b, r_c, u_a, u_b, u_c, m_warn, m_shut, m_oc} = '0;
    end else begin
      bit rs, us, flt, nw, ns, no;
      int nm, nc;
      rs = r_b; us = u_b; flt = m_shut | m_oc;
      nw = (temp_hot_i | temp_crit_i) ? 1'b1 : (temp_cool_i ? 1'b0 : m_warn);
      ns = temp_crit_i ? 1'b1 : (temp_cool_i ? 1'b0 : m_shut);
      no = (oc_i != 0) ? 1'b1 : (((r_b && !r_c) || (u_b && !u_c)) ? 1'b0 : m_oc);
      nm = m_mode; nc = m_cnt + 1;
      if (!rs) begin nm = 0; nc = 0; end
      else if (m_mode == 0) begin nm = 1; nc = 0; end
      else if (m_mode == 1) begin if (m_cnt == INI - 1) begin nm = 2; nc = 0; end end
      else if (m_mode == 2) begin nc = 0; if (us && !flt) nm = 3; end
      else if (m_mode == 3) begin
        if (!us || flt) begin nm = 2; nc = 0; end
        else if (m_cnt == UNM - 1) begin nm = 4; nc = 0; end
      end else if (m_mode == 4) begin
        nc = 0; if (flt) nm = 2; else if (!us) nm = 5;
      end else begin
        if (flt) begin nm = 2; nc = 0; end
        else if (us) begin nm = 4; nc = 0; end
        else if (m_cnt == MUT - 1) begin nm = 2; nc = 0; end
      end
      r_c = r_b; r_b = r_a; r_a = amp_reset_ni;
      u_c = u_b; u_b = u_a; u_a = mute_ni;
      m_warn = nw; m_shut = ns; m_oc = no; m_mode = nm; m_cnt = nc;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R2 mod_en", mod_en_o, (m_mode != 0));
      chk("R3 stage_en", stage_en_o, (m_mode == 4 || m_mode == 5));
      chk("R5 err_warn", err_warn_no, !m_warn);
      chk("R6 err_shut", err_shut_no, !m_shut);
      chk("R8 err_oc", err_oc_no, !m_oc);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lat(string req, ref logic sig, input logic val, input int exp);
    int k = 0;
    while (sig !== val && k < 500) begin @(negedge clk); k++; end
    chk(req, k, exp);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all reqs): actual=expired expected=finished");
    summary();
  end

  initial begin
    bit ok;
    cyc(3);
    rst_ni = 1'b1;
    cyc(5);
    // R1 reset state
    chk("R1 mod off", mod_en_o, 0);
    chk("R1 stage off", stage_en_o, 0);
    chk("R1 errors idle", {err_warn_no, err_shut_no, err_oc_no}, 7);
    // R2 init then muted idle
    amp_reset_ni = 1'b1;
    lat("R2 init latency", mod_en_o, 1'b1, 3);
    cyc(INI + 2);
    chk("R2 idle muted", {mod_en_o, stage_en_o}, 2);
    // R3 unmute latency
    mute_ni = 1'b1;
    lat("R3 unmute latency", stage_en_o, 1'b1, UNM + 3);
    cyc(5);
    // R4 mute latency
    mute_ni = 1'b0;
    lat("R4 mute latency", stage_en_o, 1'b0, MUT + 3);
    mute_ni = 1'b1;
    cyc(UNM + 6);
    // R11 unmute during wind-down
    mute_ni = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 5; i++) begin cyc(1); if (!stage_en_o) ok = 1'b0; end
    mute_ni = 1'b1;
    for (int i = 0; i < 20; i++) begin cyc(1); if (!stage_en_o) ok = 1'b0; end
    chk("R11 no gap", ok, 1);
    // R5 warning with hysteresis
    temp_cool_i = 1'b0; temp_hot_i = 1'b1;
    cyc(1);
    chk("R5 warn set", err_warn_no, 0);
    temp_hot_i = 1'b0;
    cyc(6);
    chk("R5 warn held", err_warn_no, 0);
    chk("R5 still running", stage_en_o, 1);
    // R6 shutdown, overlapping a mute wind-down
    mute_ni = 1'b0;
    cyc(4);
    temp_crit_i = 1'b1;
    cyc(1);
    chk("R6 shut flagged", err_shut_no, 0);
    cyc(1);
    chk("R6 stage dropped", stage_en_o, 0);
    mute_ni = 1'b1;
    temp_crit_i = 1'b0;
    cyc(UNM + 10);
    chk("R7 shut held", {err_shut_no, stage_en_o}, 0);
    // R7 recovery through soft start
    temp_cool_i = 1'b1;
    lat("R7 restart latency", stage_en_o, 1'b1, UNM + 2);
    chk("R7 errors cleared", {err_warn_no, err_shut_no}, 3);
    // R8 overcurrent latch
    oc_i = 8'b0010_0000;
    cyc(1);
    oc_i = '0;
    chk("R8 oc flagged", err_oc_no, 0);
    cyc(1);
    chk("R8 stage dropped", stage_en_o, 0);
    cyc(UNM + 10);
    chk("R8 oc latched", {err_oc_no, stage_en_o}, 0);
    // R10 release while flag still high
    oc_i = 8'b0000_0001;
    mute_ni = 1'b0; cyc(5); mute_ni = 1'b1;
    cyc(UNM + 10);
    chk("R10 set wins", {err_oc_no, stage_en_o}, 0);
    // R9 mute release clears
    oc_i = '0;
    mute_ni = 1'b0; cyc(5); mute_ni = 1'b1;
    cyc(2);
    chk("R9 not yet cleared", err_oc_no, 0);
    cyc(1);
    chk("R9 cleared by mute", err_oc_no, 1);
    lat("R9 restart", stage_en_o, 1'b1, UNM + 1);
    // R12 mute during soft start
    mute_ni = 1'b0; cyc(MUT + 6);
    mute_ni = 1'b1; cyc(10); mute_ni = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < UNM + 10; i++) begin cyc(1); if (stage_en_o) ok = 1'b0; end
    chk("R12 abort soft", ok, 1);
    mute_ni = 1'b1;
    cyc(UNM + 6);
    chk("R12 run again", stage_en_o, 1);
    // R13 control reset from run
    amp_reset_ni = 1'b0;
    lat("R13 reset latency", mod_en_o, 1'b0, 3);
    chk("R1 stage tristate", stage_en_o, 0);
    oc_i = 8'b1000_0000; cyc(1); oc_i = '0;
    cyc(4);
    chk("R8 latch in reset", err_oc_no, 0);
    // R9 reset release clears
    amp_reset_ni = 1'b1;
    cyc(3);
    chk("R9 cleared by reset", err_oc_no, 1);
    cyc(INI + UNM + 6);
    chk("R2 full restart", stage_en_o, 1);
    cyc(2);
    summary();
  end
endmodule